// File: doc/BRIEF.md
# Multi-Source Scanline IRQ Timer

This block is the interrupt timer of a game-cartridge bank controller. Software programs it through eight write-only byte registers, chosen by a three-bit offset. It counts events from one of four sources: CPU cycle ticks, rising edges on the video address line A12, video read strobes, or CPU-space write strobes. Each event steps an 8-bit prescaler. When the prescaler wraps, it steps an 8-bit main counter. When the main counter wraps while the interrupt is armed, the block raises its IRQ output. The output stays high until software disarms the timer.

The prescaler and counter can step up or down, or they can be frozen. The prescaler can also be narrowed so that only its low three bits take part in the wrap. Values written to the prescaler and counter are scrambled with a software-held XOR mask before they are stored. An adjust byte can halt counting when a mode bit asks for it.

Top module: `irqt_top`

## Requirements
- R1: A write at offset 0 copies data bit 0 into the arm flag, and when that bit is 0 it also drops IRQ on the next edge. A write at offset 3 sets the arm flag whatever its data.
- R2: Offset 1 holds the mode byte. Bits [1:0] pick the event source: 0 = cpu_tick, 1 = A12 rising edge, 2 = ppu_rd, 3 = bus_wr. Pulses on the sources that are not selected change nothing.
- R3: ppu_a12 passes through a two-flop synchroniser. Each low-to-high transition is one event, however long the line stays high.
- R4: Mode bits [7:6] set the direction: 2 counts down, 1 counts up, and 0 or 3 freezes both prescaler and counter.
- R5: Mode bit 2 set makes only prescaler bits [2:0] step and wrap, and leaves bits [7:3] untouched. With bit 2 clear, the whole 8-bit prescaler steps and wraps.
- R6: A write at offset 6 stores the XOR mask. Writes at offset 4 and offset 5 load the prescaler and the main counter with data XOR mask.
- R7: A write at offset 7 stores the adjust byte. When mode bit 3 is set and the adjust byte is not 0xFF, no event is counted. When mode bit 3 is clear, the adjust byte is ignored.
- R8: The main counter steps once for each prescaler wrap (0 to its top going down, top to 0 going up). IRQ rises on the edge where the counter wraps, 0x00 to 0xFF or 0xFF to 0x00, but only if the arm flag is set at that moment.
- R9: Once high, IRQ stays high through further events and through offset-0 writes with data bit 0 set.
- R10: Reset clears the arm flag, mode, IRQ, prescaler, counter, mask and adjust byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register offset |
| wr_data | input | 8 | Write data |
| cpu_tick | input | 1 | One-cycle CPU cycle event |
| ppu_a12 | input | 1 | Asynchronous video address line A12 |
| ppu_rd | input | 1 | One-cycle video read event |
| bus_wr | input | 1 | One-cycle CPU-space write event |
| irq | output | 1 | Active-high interrupt request |

## Verification
The assertions assume that cpu_tick, ppu_rd, bus_wr and register writes are synchronous one-cycle strobes. They also assume that a register write and a counting event aimed at the same register are never meant to be combined: a load simply wins. The stimulus keeps register writes and event pulses in separate cycles. It holds ppu_a12 steady for several cycles around each edge so the synchroniser sees clean transitions. Random trials choose the preload values so that the counter wraps within a bounded number of events, and bench functions predict the exact event that raises IRQ.

// File: rtl/irqt_pkg.sv
package irqt_pkg;

    localparam int unsigned REG_W    = 8;
    localparam int unsigned OFS_W    = 3;
    localparam int unsigned NARROW_W = 3;

    typedef enum logic [1:0] {
        SRC_CPU_CYC   = 2'd0,
        SRC_A12_RISE  = 2'd1,
        SRC_PPU_READ  = 2'd2,
        SRC_BUS_WRITE = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        DIR_FREEZE0 = 2'd0,
        DIR_UP      = 2'd1,
        DIR_DOWN    = 2'd2,
        DIR_FREEZE3 = 2'd3
    } dir_e;

    typedef struct packed {
        dir_e       dir;
        logic [1:0] spare;
        logic       adj_en;
        logic       narrow;
        src_e       src;
    } mode_t;

    typedef enum logic [OFS_W-1:0] {
        OFS_ARMCTL = 3'd0,
        OFS_MODE   = 3'd1,
        OFS_UNUSED = 3'd2,
        OFS_ARM    = 3'd3,
        OFS_PRE    = 3'd4,
        OFS_CNT    = 3'd5,
        OFS_MASK   = 3'd6,
        OFS_ADJ    = 3'd7
    } ofs_e;

    typedef struct packed {
        logic             wrap;
        logic [REG_W-1:0] nxt;
    } step_t;

    function automatic step_t step_val(input logic [REG_W-1:0] v,
                                       input logic up,
                                       input logic narrow);
        step_t r;
        logic [NARROW_W-1:0] lo;
        lo = v[NARROW_W-1:0];
        if (narrow) begin
            r.wrap = up ? (&lo) : (lo == '0);
            lo     = up ? lo + 1'b1 : lo - 1'b1;
            r.nxt  = {v[REG_W-1:NARROW_W], lo};
        end else begin
            r.wrap = up ? (&v) : (v == '0);
            r.nxt  = up ? v + 1'b1 : v - 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/irqt_regs.sv
module irqt_regs
    import irqt_pkg::*;
#(
    parameter int unsigned DW = REG_W,
    parameter int unsigned AW = OFS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output mode_t         mode,
    output logic [DW-1:0] mask,
    output logic [DW-1:0] adj,
    output logic          arm_set,
    output logic          arm_clr,
    output logic          pre_ld,
    output logic          cnt_ld,
    output logic [DW-1:0] ld_val
);

    ofs_e ofs;

    always_comb begin
        ofs     = ofs_e'(wr_addr);
        arm_set = wr_en && ((ofs == OFS_ARM) || (ofs == OFS_ARMCTL && wr_data[0]));
        arm_clr = wr_en && (ofs == OFS_ARMCTL) && !wr_data[0];
        pre_ld  = wr_en && (ofs == OFS_PRE);
        cnt_ld  = wr_en && (ofs == OFS_CNT);
        ld_val  = wr_data ^ mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
            mask <= '0;
            adj  <= '0;
        end else if (wr_en) begin
            case (ofs)
                OFS_MODE: mode <= mode_t'(wr_data);
                OFS_MASK: mask <= wr_data;
                OFS_ADJ:  adj  <= wr_data;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/irqt_evsel.sv
module irqt_evsel
    import irqt_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  src_e src,
    input  logic cpu_tick,
    input  logic ppu_a12,
    input  logic ppu_rd,
    input  logic bus_wr,
    output logic ev
);

    localparam int unsigned CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] a12_sh;
    logic             a12_rise;

    always_ff @(posedge clk) begin
        if (rst) a12_sh <= '0;
        else     a12_sh <= {a12_sh[CHAIN-2:0], ppu_a12};
    end

    assign a12_rise = a12_sh[CHAIN-2] & ~a12_sh[CHAIN-1];

    always_comb begin
        case (src)
            SRC_CPU_CYC:   ev = cpu_tick;
            SRC_A12_RISE:  ev = a12_rise;
            SRC_PPU_READ:  ev = ppu_rd;
            SRC_BUS_WRITE: ev = bus_wr;
            default:       ev = 1'b0;
        endcase
    end

endmodule

// File: rtl/irqt_core.sv
module irqt_core
    import irqt_pkg::*;
#(
    parameter int unsigned DW = REG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ev,
    input  mode_t         mode,
    input  logic [DW-1:0] adj,
    input  logic          arm_set,
    input  logic          arm_clr,
    input  logic          pre_ld,
    input  logic          cnt_ld,
    input  logic [DW-1:0] ld_val,
    output logic          armed,
    output logic [DW-1:0] pre,
    output logic [DW-1:0] cnt,
    output logic          irq
);

    logic  moving, gate_ok, up, tick, cstep, fire;
    step_t ps, cs;

    always_comb begin
        moving  = (mode.dir == DIR_UP) || (mode.dir == DIR_DOWN);
        gate_ok = !mode.adj_en || (adj == '1);
        up      = (mode.dir == DIR_UP);
        ps      = step_val(pre, up, mode.narrow);
        cs      = step_val(cnt, up, 1'b0);
        tick    = ev && moving && gate_ok && !pre_ld;
        cstep   = tick && ps.wrap && !cnt_ld;
        fire    = cstep && cs.wrap && armed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            pre   <= '0;
            cnt   <= '0;
            irq   <= 1'b0;
        end else begin
            if (arm_set)      armed <= 1'b1;
            else if (arm_clr) armed <= 1'b0;

            if (pre_ld)    pre <= ld_val;
            else if (tick) pre <= ps.nxt;

            if (cnt_ld)     cnt <= ld_val;
            else if (cstep) cnt <= cs.nxt;

            if (arm_clr)   irq <= 1'b0;
            else if (fire) irq <= 1'b1;
        end
    end

endmodule

// File: rtl/irqt_top.sv
module irqt_top
    import irqt_pkg::*;
#(
    parameter int unsigned DW          = REG_W,
    parameter int unsigned AW          = OFS_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          cpu_tick,
    input  logic          ppu_a12,
    input  logic          ppu_rd,
    input  logic          bus_wr,
    output logic          irq
);

    mode_t         mode_w;
    logic [DW-1:0] mask_w, adj_w, ld_val_w, pre_w, cnt_w;
    logic          arm_set_w, arm_clr_w, pre_ld_w, cnt_ld_w, ev_w, armed_w;

    irqt_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mode(mode_w), .mask(mask_w), .adj(adj_w),
        .arm_set(arm_set_w), .arm_clr(arm_clr_w),
        .pre_ld(pre_ld_w), .cnt_ld(cnt_ld_w), .ld_val(ld_val_w)
    );

    irqt_evsel #(.SYNC_STAGES(SYNC_STAGES)) u_evsel (
        .clk(clk), .rst(rst), .src(mode_w.src),
        .cpu_tick(cpu_tick), .ppu_a12(ppu_a12), .ppu_rd(ppu_rd), .bus_wr(bus_wr),
        .ev(ev_w)
    );

    irqt_core #(.DW(DW)) u_core (
        .clk(clk), .rst(rst), .ev(ev_w), .mode(mode_w), .adj(adj_w),
        .arm_set(arm_set_w), .arm_clr(arm_clr_w),
        .pre_ld(pre_ld_w), .cnt_ld(cnt_ld_w), .ld_val(ld_val_w),
        .armed(armed_w), .pre(pre_w), .cnt(cnt_w), .irq(irq)
    );

endmodule

// File: rtl/irqt_chk.sv
module irqt_chk #(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic [DW-1:0] mode,
    input logic [DW-1:0] mask,
    input logic [DW-1:0] adj,
    input logic          armed,
    input logic [DW-1:0] pre,
    input logic [DW-1:0] cnt,
    input logic          irq
);

    logic disarm_wr, load_wr, frozen, halted;
    assign disarm_wr = wr_en && (wr_addr == 3'd0) && !wr_data[0];
    assign load_wr   = wr_en && (wr_addr == 3'd4 || wr_addr == 3'd5);
    assign frozen    = !(mode[7:6] == 2'b01 || mode[7:6] == 2'b10);
    assign halted    = mode[3] && (adj != '1);

    a_r1_disarm_drops_irq: assert property (@(posedge clk) disable iff (rst)
        disarm_wr |=> (!irq && !armed));

    a_r1_arm_write_sets: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd3) |=> armed);

    a_r4_frozen_holds: assert property (@(posedge clk) disable iff (rst)
        (frozen && !load_wr) |=> ($stable(pre) && $stable(cnt)));

    a_r6_pre_load: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd4) |=> (pre == $past(wr_data ^ mask)));

    a_r6_cnt_load: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd5) |=> (cnt == $past(wr_data ^ mask)));

    a_r7_adjust_halts: assert property (@(posedge clk) disable iff (rst)
        (halted && !load_wr) |=> ($stable(pre) && $stable(cnt)));

    a_r8_irq_needs_arm: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(armed));

    a_r9_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq && !disarm_wr) |=> irq);

endmodule

bind irqt_top irqt_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode(mode_w), .mask(mask_w), .adj(adj_w), .armed(armed_w),
    .pre(pre_w), .cnt(cnt_w), .irq(irq)
);

// File: tb/tb_irqt_top.sv
module tb_irqt_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       cpu_tick = 1'b0, ppu_a12 = 1'b0, ppu_rd = 1'b0, bus_wr = 1'b0;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irqt_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cpu_tick(cpu_tick), .ppu_a12(ppu_a12), .ppu_rd(ppu_rd), .bus_wr(bus_wr),
        .irq(irq)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s irq actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic cfg(input logic [1:0] src, input logic [1:0] dir,
                       input logic narrow, input logic adj_en);
        wr(3'd1, {dir, 2'b00, adj_en, narrow, src});
    endtask

    task automatic load(input logic [7:0] p, input logic [7:0] c, input logic [7:0] m);
        wr(3'd6, m); wr(3'd4, p ^ m); wr(3'd5, c ^ m);
    endtask

    task automatic pulse(input int src);
        if (src == 1) begin
            @(negedge clk); ppu_a12 = 1'b1;
            repeat (3) @(negedge clk);
            ppu_a12 = 1'b0;
            repeat (3) @(negedge clk);
        end else begin
            @(negedge clk);
            case (src)
                0: cpu_tick = 1'b1;
                2: ppu_rd   = 1'b1;
                default: bus_wr = 1'b1;
            endcase
            @(negedge clk); cpu_tick = 1'b0; ppu_rd = 1'b0; bus_wr = 1'b0;
        end
    endtask

    // Number of events until the main counter wraps, from R5 and R8.
    function automatic int events_to_wrap(input logic [7:0] p, input logic [7:0] c,
                                          input bit up, input bit narrow);
        for (int k = 1; k < 70000; k++) begin
            bit pw;
            if (narrow) begin
                pw = up ? (p[2:0] == 3'd7) : (p[2:0] == 3'd0);
                p[2:0] = up ? p[2:0] + 3'd1 : p[2:0] - 3'd1;
            end else begin
                pw = up ? (p == 8'hFF) : (p == 8'h00);
                p = up ? p + 8'd1 : p - 8'd1;
            end
            if (pw) begin
                if (up ? (c == 8'hFF) : (c == 8'h00)) return k;
                c = up ? c + 8'd1 : c - 8'd1;
            end
        end
        return 0;
    endfunction

    task automatic rearm();
        wr(3'd0, 8'h00); wr(3'd3, 8'h00);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed_init;
        seed_init = $urandom(32'h5EED_1234);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state, irq low and mode frozen
        chk("R10 reset irq", irq, 1'b0);
        wr(3'd3, 8'h00);
        repeat (4) pulse(0);
        chk("R10 mode cleared so no counting", irq, 1'b0);
        // R10: prescaler and counter reset to zero, one down event wraps both
        cfg(2'd0, 2'd2, 1'b0, 1'b0);
        pulse(0);
        chk("R10/R4 zero state down wraps at once", irq, 1'b1);

        // R9 sticky, R1 clear
        pulse(0);
        chk("R9 sticky after events", irq, 1'b1);
        wr(3'd0, 8'h01);
        chk("R9 arm write keeps irq", irq, 1'b1);
        wr(3'd0, 8'h00);
        chk("R1 disarm clears irq", irq, 1'b0);

        // R8: disarmed wrap gives no irq
        load(8'h00, 8'h00, 8'h00);
        pulse(0);
        chk("R8 no irq while disarmed", irq, 1'b0);
        wr(3'd3, 8'h5A);
        load(8'h00, 8'h00, 8'h00);
        pulse(0);
        chk("R1 offset 3 arms", irq, 1'b1);
        rearm();

        // R4: direction code 3 freezes
        cfg(2'd0, 2'd3, 1'b0, 1'b0);
        load(8'h00, 8'h00, 8'h00);
        repeat (5) pulse(0);
        chk("R4 freeze code 3", irq, 1'b0);

        // R2: unselected sources ignored
        cfg(2'd2, 2'd2, 1'b0, 1'b0);
        load(8'h00, 8'h00, 8'h00);
        pulse(0); pulse(1); pulse(3);
        chk("R2 unselected sources ignored", irq, 1'b0);
        pulse(2);
        chk("R2 ppu_rd source counts", irq, 1'b1);
        rearm();

        // R3: long A12 high is one event
        cfg(2'd1, 2'd2, 1'b0, 1'b0);
        load(8'h01, 8'h00, 8'h00);
        @(negedge clk); ppu_a12 = 1'b1;
        repeat (20) @(negedge clk);
        ppu_a12 = 1'b0;
        repeat (4) @(negedge clk);
        chk("R3 level high counts once", irq, 1'b0);
        pulse(1);
        chk("R3 second rise counts", irq, 1'b1);
        rearm();

        // R7: adjust byte gating
        wr(3'd7, 8'h7F);
        cfg(2'd0, 2'd2, 1'b0, 1'b1);
        load(8'h00, 8'h00, 8'h00);
        pulse(0);
        chk("R7 adjust not FF halts", irq, 1'b0);
        wr(3'd7, 8'hFF);
        pulse(0);
        chk("R7 adjust FF counts", irq, 1'b1);
        rearm();
        wr(3'd7, 8'h12);
        cfg(2'd0, 2'd2, 1'b0, 1'b0);
        load(8'h00, 8'h00, 8'h00);
        pulse(0);
        chk("R7 adjust ignored with bit 3 clear", irq, 1'b1);
        rearm();

        // R5: narrow prescaler keeps upper bits; 0xF8 down needs 9 events to wrap counter 1
        cfg(2'd3, 2'd2, 1'b1, 1'b0);
        load(8'hF8, 8'h01, 8'hC3);
        repeat (8) pulse(3);
        chk("R5 narrow no wrap before ninth", irq, 1'b0);
        pulse(3);
        chk("R5 narrow wrap on ninth", irq, 1'b1);
        rearm();

        // Random trials: R2 R4 R5 R6 R8 R9 R1
        for (int t = 0; t < 24; t++) begin
            int   src, n;
            bit   up, narrow, adj_en;
            logic [7:0] p, c, m;
            src    = int'($urandom % 4);
            up     = 1'($urandom % 2);
            narrow = (src == 1) ? 1'b1 : 1'($urandom % 2);
            adj_en = 1'($urandom % 2);
            m      = 8'($urandom);
            p      = 8'($urandom);
            c      = up ? 8'hFD + 8'($urandom % 3) : 8'($urandom % 3);
            n      = events_to_wrap(p, c, up, narrow);
            wr(3'd7, 8'hFF);
            cfg(2'(src), up ? 2'd1 : 2'd2, narrow, adj_en);
            load(p, c, m);
            for (int k = 0; k < n - 1; k++) pulse(src);
            chk("R8 R6 no irq before predicted wrap", irq, 1'b0);
            pulse(src);
            chk("R8 R5 R2 irq at predicted wrap", irq, 1'b1);
            pulse(src);
            chk("R9 stays high", irq, 1'b1);
            wr(3'd0, 8'h00);
            chk("R1 cleared", irq, 1'b0);
            wr(3'd3, 8'h00);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule